// File: doc/BRIEF.md
# Crossbar Clock Output Channel Bank

This block is a bank of identical clock output channels. Each channel takes one of up to 64 reference clocks through a crossbar select. The selected clock then passes through a gated pre-divider and a final divider, and leaves through a final gate. An optional retiming stage sits on the output path. Software configures the whole bank through a flat word-addressed register port with address, write data, write enable and combinational read data. The source selects for four channels share one 32-bit crossbar word.

All logic runs on one fast system clock. Each reference clock arrives as a level that is sampled on that clock, so a reference must toggle no faster than once per system clock cycle. The dividers count rising edges of their input level. The two gates open and close only while the signal they gate is low, so a gate change never produces a shortened pulse.

To enable a channel, software sets both gate bits. To disable it, software clears only the final gate. The pre-divider gate keeps its setting.

Top module: `clkxbar_bank`

## Requirements
- R1: After reset every register reads 0, all gates are closed and every `clkOut` bit is low.
- R2: The crossbar word for channel i is at byte address 0x18 + 4*floor(i/4), in the byte lane starting at bit 8*(i mod 4). In that lane, bits 5:0 are the source select and bit 6 is the pre-divider gate. Bit 7 of each lane, and lanes with no channel, read 0.
- R3: The pre-divider ratio of channel i is in bits 9:0 of the word at 0x58 + 4*i. All other bits of that word read 0.
- R4: The final word of channel i is at 0x164 + 4*i. Bits 5:0 hold the final ratio, bit 6 is the final gate and bit 7 selects retimed (synchronous) output. Bits 31:8 read 0.
- R5: Writes to any other address change no register, and reads from any other address return 0.
- R6: A select value s below the number of references routes `refIn[s]` to the channel. A select at or above that count gives a channel with no clock, and its output stays low.
- R7: A ratio field value N divides by N+1 in each stage. The output period is the reference period times (P+1)*(F+1).
- R8: For a ratio field of 0, a stage passes its input unchanged. For an even division the stage output is high for half of its period. For an odd division the high phase is one input period shorter than the low phase.
- R9: Clearing the final gate forces the output low and leaves the pre-divider gate setting unchanged. Setting the final gate again restarts the output.
- R10: With the pre-divider gate closed the output makes no rising edge. Clearing the pre-divider gate leaves the final word unchanged.
- R11: A gate opens or closes only while the signal it gates is low. A high pulse that is in progress when the final gate is cleared completes at its full width, and the first pulse after the gate opens also has full width.
- R12: With both ratios 0, `clkOut` equals the selected reference delayed by one system clock edge when bit 7 of the final word is 0, and by two edges when it is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples the references and runs all state |
| rstN | input | 1 | Asynchronous active-low reset |
| refIn | input | NUM_REF | Reference clock levels |
| regAddr | input | 12 | Byte address of the register word |
| regWrData | input | 32 | Write data |
| regWrEn | input | 1 | Write strobe, takes effect at the clock edge |
| regRdData | output | 32 | Read data for `regAddr`, combinational |
| clkOut | output | NUM_CH | Per-channel output clocks |

## Verification
The bench sweeps every reference against several pre and final ratios. It also tries the extreme ratios 1023 and 63. Period and high time are computed arithmetically, so a stage dividing by N instead of N+1, or a wrong odd-ratio duty, shows up directly.

The lane layout is checked with patterns that differ per byte. A lane shifted by one channel, or a bit 7 that is writable, corrupts the readback.

The final gate is cleared in the cycle after a rising edge of the output. A gate that follows its enable bit at once truncates that pulse, and the truncation shows in the count of high cycles. A select beyond the reference count, a closed pre-divider gate and the retiming bit each give an output that is either silent or shifted in time, and each is compared against the expected waveform.

// File: rtl/clkxbar_pkg.sv
`timescale 1ns/1ps
package clkxbar_pkg;
  localparam int ADDR_W    = 12;
  localparam int SEL_W     = 6;
  localparam int PRE_W     = 10;
  localparam int FIN_W     = 6;
  localparam int XBAR_BASE = 'h018;
  localparam int PRE_BASE  = 'h058;
  localparam int FIN_BASE  = 'h164;

  typedef struct packed {
    logic [SEL_W-1:0] srcSel;
    logic             preGateEn;
    logic [PRE_W-1:0] preRatio;
    logic [FIN_W-1:0] finRatio;
    logic             finGateEn;
    logic             syncMode;
  } chanCfg_t;

  function automatic logic [ADDR_W-1:0] xbarAddr(input int idx);
    return ADDR_W'(XBAR_BASE + 4 * (idx / 4));
  endfunction

  function automatic logic [ADDR_W-1:0] preAddr(input int idx);
    return ADDR_W'(PRE_BASE + 4 * idx);
  endfunction

  function automatic logic [ADDR_W-1:0] finAddr(input int idx);
    return ADDR_W'(FIN_BASE + 4 * idx);
  endfunction
endpackage

// File: rtl/clkxbar_regs.sv
`timescale 1ns/1ps
module clkxbar_regs
  import clkxbar_pkg::*;
#(
  parameter int NUM_CH = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [31:0]             regWrData,
  input  logic                    regWrEn,
  output logic [31:0]             regRdData,
  output chanCfg_t [NUM_CH-1:0]   chCfg
);
  chanCfg_t [NUM_CH-1:0] cfgQ;

  // Write decode: each channel owns a byte lane in a crossbar word plus two private words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (regWrEn) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (regAddr == xbarAddr(i)) begin
          cfgQ[i].srcSel    <= regWrData[8*(i%4) +: SEL_W];
          cfgQ[i].preGateEn <= regWrData[8*(i%4) + 6];
        end
        if (regAddr == preAddr(i)) begin
          cfgQ[i].preRatio <= regWrData[PRE_W-1:0];
        end
        if (regAddr == finAddr(i)) begin
          cfgQ[i].finRatio  <= regWrData[FIN_W-1:0];
          cfgQ[i].finGateEn <= regWrData[6];
          cfgQ[i].syncMode  <= regWrData[7];
        end
      end
    end
  end

  // Read decode: unmapped addresses and unused bits return zero
  always_comb begin
    regRdData = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (regAddr == xbarAddr(i))
        regRdData[8*(i%4) +: 8] = {1'b0, cfgQ[i].preGateEn, cfgQ[i].srcSel};
      if (regAddr == preAddr(i))
        regRdData = {{(32-PRE_W){1'b0}}, cfgQ[i].preRatio};
      if (regAddr == finAddr(i))
        regRdData = {24'b0, cfgQ[i].syncMode, cfgQ[i].finGateEn, cfgQ[i].finRatio};
    end
  end

  assign chCfg = cfgQ;

  // R4: a write to channel 0's final word lands in its ratio field
  assert_fin_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == finAddr(0)) |=> (cfgQ[0].finRatio == $past(regWrData[FIN_W-1:0])));
endmodule

// File: rtl/clkxbar_divstage.sv
`timescale 1ns/1ps
module clkxbar_divstage #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inLvl,
  input  logic [W-1:0] ratio,
  output logic         outLvl
);
  logic         inPrev;
  logic         inRise;
  logic [W-1:0] cnt;
  logic [W-1:0] cntNext;
  logic [W:0]   ratioPlus;
  logic [W:0]   halfCnt;
  logic         divQ;

  assign inRise    = inLvl & ~inPrev;
  assign cntNext   = (cnt >= ratio) ? '0 : cnt + W'(1);
  assign ratioPlus = {1'b0, ratio} + (W+1)'(1);
  assign halfCnt   = ratioPlus >> 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inPrev <= 1'b0;
      cnt    <= '0;
      divQ   <= 1'b0;
    end else begin
      inPrev <= inLvl;
      if (inRise) begin
        cnt  <= cntNext;
        divQ <= ({1'b0, cntNext} < halfCnt);
      end
    end
  end

  assign outLvl = (ratio == '0) ? inLvl : divQ;

  // R7: the edge counter never runs past the programmed ratio
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    inRise |=> (cnt <= $past(ratio)));
endmodule

// File: rtl/clkxbar_chan.sv
`timescale 1ns/1ps
module clkxbar_chan
  import clkxbar_pkg::*;
#(
  parameter int NUM_REF = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REF-1:0] refIn,
  input  chanCfg_t           cfg,
  output logic               clkOut
);
  logic [63:0] refExt;
  logic        srcLvl;
  logic        preGateOpen;
  logic        preIn;
  logic        preLvl;
  logic        finLvl;
  logic        finGateOpen;
  logic        gatedLvl;
  logic        syncQ;

  assign refExt = 64'(refIn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcLvl      <= 1'b0;
      preGateOpen <= 1'b0;
      finGateOpen <= 1'b0;
      syncQ       <= 1'b0;
    end else begin
      srcLvl <= refExt[cfg.srcSel];
      if (!srcLvl) preGateOpen <= cfg.preGateEn;
      if (!finLvl) finGateOpen <= cfg.finGateEn;
      syncQ <= gatedLvl;
    end
  end

  assign preIn = srcLvl & preGateOpen;

  clkxbar_divstage #(.W(PRE_W)) preDiv_i (
    .clk(clk), .rstN(rstN), .inLvl(preIn), .ratio(cfg.preRatio), .outLvl(preLvl)
  );

  clkxbar_divstage #(.W(FIN_W)) finDiv_i (
    .clk(clk), .rstN(rstN), .inLvl(preLvl), .ratio(cfg.finRatio), .outLvl(finLvl)
  );

  assign gatedLvl = finLvl & finGateOpen;
  assign clkOut   = cfg.syncMode ? syncQ : gatedLvl;

  // R11: the pre-divider gate moves only while the selected source is low
  assert_pregate_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    (preGateOpen != $past(preGateOpen)) |-> !$past(srcLvl));

  // R11: the final gate moves only while the final divider output is low
  assert_fingate_low_R11: assert property (@(posedge clk) disable iff (!rstN)
    (finGateOpen != $past(finGateOpen)) |-> !$past(finLvl));
endmodule

// File: rtl/clkxbar_bank.sv
`timescale 1ns/1ps
module clkxbar_bank
  import clkxbar_pkg::*;
#(
  parameter int NUM_CH  = 6,
  parameter int NUM_REF = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_REF-1:0] refIn,
  input  logic [11:0]        regAddr,
  input  logic [31:0]        regWrData,
  input  logic               regWrEn,
  output logic [31:0]        regRdData,
  output logic [NUM_CH-1:0]  clkOut
);
  chanCfg_t [NUM_CH-1:0] chCfg;

  clkxbar_regs #(.NUM_CH(NUM_CH)) regs_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdData(regRdData), .chCfg(chCfg)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    clkxbar_chan #(.NUM_REF(NUM_REF)) chan_i (
      .clk(clk), .rstN(rstN), .refIn(refIn), .cfg(chCfg[g]), .clkOut(clkOut[g])
    );
  end
endmodule

// File: tb/clkxbar_bank_tb_top.sv
`timescale 1ns/1ps
module clkxbar_bank_tb_top;
  localparam int NCH  = 6;
  localparam int NREF = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [NREF-1:0]  refIn = '0;
  logic [11:0]      regAddr = '0;
  logic [31:0]      regWrData = '0;
  logic             regWrEn = 1'b0;
  logic [31:0]      regRdData;
  logic [NCH-1:0]   clkOut;

  always #10 clk = ~clk;

  clkxbar_bank #(.NUM_CH(NCH), .NUM_REF(NREF)) dut_i (
    .clk(clk), .rstN(rstN), .refIn(refIn), .regAddr(regAddr),
    .regWrData(regWrData), .regWrEn(regWrEn), .regRdData(regRdData), .clkOut(clkOut)
  );

  int tests = 0;
  int fails = 0;
  int unsigned tick = 0;
  logic [31:0] xw [2];

  // reference j toggles every j+1 system cycles: period 2*(j+1)
  initial forever begin
    @(negedge clk);
    tick++;
    for (int j = 0; j < NREF; j++) refIn[j] = ((tick / (j + 1)) % 2) == 1;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic setChan(input int c, input int sel, input bit pg, input int p,
                         input int f, input bit fg, input bit sy);
    xw[c/4][8*(c%4) +: 8] = {1'b0, pg, 6'(sel)};
    wr(12'(24 + 4*(c/4)), xw[c/4]);
    wr(12'(88 + 4*c), 32'(p));
    wr(12'(356 + 4*c), {24'b0, sy, fg, 6'(f)});
  endtask

  task automatic sample();
    @(posedge clk);
    #2;
  endtask

  task automatic waitRise(input int c, input int lim, output bit seen);
    logic prev;
    seen = 1'b0;
    sample();
    prev = clkOut[c];
    for (int n = 0; n < lim; n++) begin
      sample();
      if (!prev && clkOut[c]) begin seen = 1'b1; return; end
      prev = clkOut[c];
    end
  endtask

  task automatic measure(input int c, input int lim, output int hi, output int per);
    bit seen;
    hi = -1; per = -1;
    waitRise(c, lim, seen);
    if (!seen) return;
    hi = 0; per = 0;
    while (clkOut[c] && per < lim) begin sample(); hi++; per++; end
    while (!clkOut[c] && per < lim) begin sample(); per++; end
  endtask

  function automatic void expected(input int sel, input int p, input int f,
                                   output int eh, output int ep);
    int tr, tp, ph;
    tr = 2 * (sel + 1);
    tp = tr * (p + 1);
    ph = (p == 0) ? (sel + 1) : ((p + 1) / 2) * tr;
    if (f == 0) begin ep = tp; eh = ph; end
    else begin ep = tp * (f + 1); eh = ((f + 1) / 2) * tp; end
  endfunction

  task automatic runCase(input string tag, input int c, input int sel, input int p, input int f);
    int h, per, eh, ep;
    expected(sel, p, f, eh, ep);
    setChan(c, sel, 1'b1, p, f, 1'b1, 1'b0);
    measure(c, 4*ep + 40, h, per);
    measure(c, 4*ep + 40, h, per);
    chk($sformatf("R7 %s period ch%0d sel%0d p%0d f%0d", tag, c, sel, p, f), per, ep);
    chk($sformatf("R8 %s high ch%0d sel%0d p%0d f%0d", tag, c, sel, p, f), h, eh);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #3000000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d, keep;
    int h, per, cnt, mism, idx;
    logic prevR;
    bit seen;
    int pList [4] = '{0, 1, 2, 3};
    int fList [4] = '{0, 1, 2, 5};
    xw[0] = '0; xw[1] = '0;

    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state
    rd(12'h018, d); chk("R1 xbar word 0", d, 0);
    rd(12'h01C, d); chk("R1 xbar word 1", d, 0);
    for (int c = 0; c < NCH; c++) begin
      rd(12'(88 + 4*c), d);  chk($sformatf("R1 pre word ch%0d", c), d, 0);
      rd(12'(356 + 4*c), d); chk($sformatf("R1 final word ch%0d", c), d, 0);
    end
    cnt = 0;
    for (int k = 0; k < 30; k++) begin sample(); if (clkOut != '0) cnt++; end
    chk("R1 outputs low", cnt, 0);

    // R2: lane layout and masking
    wr(12'h018, 32'hFFFF_FFFF); rd(12'h018, d); chk("R2 all-ones lanes", d, 32'h7F7F_7F7F);
    wr(12'h018, 32'h1234_5678); rd(12'h018, d); chk("R2 per-lane pattern", d, 32'h1234_5678 & 32'h7F7F_7F7F);
    wr(12'h01C, 32'hDEAD_BEEF); rd(12'h01C, d); chk("R2 partial word", d, 32'h0000_3E6F);
    // R3, R4: private words
    wr(12'h058, 32'hFFFF_FFFF); rd(12'h058, d); chk("R3 pre mask", d, 32'h3FF);
    wr(12'h06C, 32'h0000_0155); rd(12'h06C, d); chk("R3 pre ch5", d, 32'h155);
    wr(12'h164, 32'hFFFF_FFFF); rd(12'h164, d); chk("R4 final mask", d, 32'hFF);
    wr(12'h178, 32'h0000_00A9); rd(12'h178, d); chk("R4 final ch5", d, 32'hA9);
    // R5: unmapped space
    rd(12'h058, keep);
    wr(12'h000, 32'hFFFF_FFFF); wr(12'h054, 32'hFFFF_FFFF); wr(12'h070, 32'hFFFF_FFFF);
    wr(12'h160, 32'hFFFF_FFFF); wr(12'h17C, 32'hFFFF_FFFF); wr(12'h020, 32'hFFFF_FFFF);
    rd(12'h000, d); chk("R5 read 0x000", d, 0);
    rd(12'h070, d); chk("R5 read 0x070", d, 0);
    rd(12'h17C, d); chk("R5 read 0x17C", d, 0);
    rd(12'h020, d); chk("R5 read 0x020", d, 0);
    rd(12'h058, d); chk("R5 neighbour kept", d, keep);

    // clear everything
    wr(12'h018, 0); wr(12'h01C, 0);
    for (int c = 0; c < NCH; c++) begin wr(12'(88 + 4*c), 0); wr(12'(356 + 4*c), 0); end
    xw[0] = '0; xw[1] = '0;

    // R7/R8 sweep over references and ratios
    idx = 0;
    for (int s = 0; s < NREF; s++)
      for (int pi = 0; pi < 4; pi++)
        for (int fi = 0; fi < 4; fi++) begin
          runCase("sweep", idx % NCH, s, pList[pi], fList[fi]);
          idx++;
        end
    runCase("max pre", 1, 0, 1023, 0);
    runCase("max final", 2, 0, 0, 63);
    runCase("odd both", 3, 1, 4, 2);

    // R6: select beyond the reference count
    setChan(1, 5, 1'b1, 0, 0, 1'b1, 1'b0);
    repeat (5) sample();
    cnt = 0;
    for (int k = 0; k < 60; k++) begin sample(); if (clkOut[1]) cnt++; end
    chk("R6 select 5 silent", cnt, 0);
    setChan(1, 63, 1'b1, 0, 0, 1'b1, 1'b0);
    repeat (5) sample();
    cnt = 0;
    for (int k = 0; k < 60; k++) begin sample(); if (clkOut[1]) cnt++; end
    chk("R6 select 63 silent", cnt, 0);

    // R12: latency with and without retiming
    setChan(0, 1, 1'b1, 0, 0, 1'b1, 1'b0);
    repeat (6) sample();
    mism = 0;
    for (int k = 0; k < 24; k++) begin sample(); if (clkOut[0] !== refIn[1]) mism++; end
    chk("R12 direct path mismatches", mism, 0);
    setChan(0, 1, 1'b1, 0, 0, 1'b1, 1'b1);
    repeat (6) sample();
    prevR = refIn[1];
    mism = 0;
    for (int k = 0; k < 24; k++) begin
      sample();
      if (clkOut[0] !== prevR) mism++;
      prevR = refIn[1];
    end
    chk("R12 retimed path mismatches", mism, 0);

    // R9: final gate off, pre gate kept, then restart
    setChan(4, 2, 1'b1, 0, 1, 1'b1, 1'b0);
    measure(4, 200, h, per);
    wr(12'(356 + 16), {24'b0, 1'b0, 1'b0, 6'd1});
    repeat (10) sample();
    cnt = 0;
    for (int k = 0; k < 60; k++) begin sample(); if (clkOut[4]) cnt++; end
    chk("R9 output low with final gate off", cnt, 0);
    rd(12'h01C, d); chk("R9 pre gate bit kept", (d >> 6) & 1, 1);
    wr(12'(356 + 16), {24'b0, 1'b0, 1'b1, 6'd1});
    measure(4, 200, h, per);
    measure(4, 200, h, per);
    chk("R9 restarted period", per, 12);

    // R10: pre gate off freezes the output
    setChan(5, 0, 1'b1, 1, 0, 1'b1, 1'b0);
    measure(5, 100, h, per);
    setChan(5, 0, 1'b0, 1, 0, 1'b1, 1'b0);
    repeat (10) sample();
    waitRise(5, 100, seen);
    chk("R10 no rising edge with pre gate off", seen, 0);
    rd(12'(356 + 20), d); chk("R10 final word kept", d, 32'h40);

    // R11: gate closed mid-pulse lets the pulse finish; reopening gives a full pulse
    setChan(2, 0, 1'b1, 0, 3, 1'b1, 1'b0);
    measure(2, 100, h, per);
    waitRise(2, 100, seen);
    cnt = 1;
    fork
      wr(12'(356 + 8), {24'b0, 1'b0, 1'b0, 6'd3});
      for (int k = 0; k < 30; k++) begin sample(); if (clkOut[2]) cnt++; end
    join
    chk("R11 final pulse full width then silent", cnt, 4);
    wr(12'(356 + 8), {24'b0, 1'b0, 1'b1, 6'd3});
    measure(2, 100, h, per);
    chk("R11 first pulse after opening", h, 4);

    summary();
  end
endmodule